// File: doc/BRIEF.md
# Two-Level Keyed Write Guard

This block sits between an address/data access port and a byte-wide memory. For every access it decides whether the write may reach the memory and whether the memory's read data may be returned. It holds three 32-bit words: a volatile entry word and two stored key settings. The access privilege follows from comparing the entry word with the settings. Level 2 is the higher level and includes every right of level 1. Both settings and the entry word reset to zero, so a freshly reset block grants level 2 and leaves every area open. Protection starts once a setting is changed to a value other than the one held in the entry word.

The entry word and the two settings are held inside the guard and are never forwarded to the memory. A setting is written one byte at a time into a staging register. The whole word is replaced only when its least significant byte is written, so the level cannot collapse in the middle of a setting update. A disallowed write is dropped without any signal. A read of a hidden location returns zero. The level is recomputed combinationally from the held words, so a change applies from the access after the write's clock edge.

Top module: `keyed_write_guard`

## Requirements
- R1: After reset the entry word and both settings are zero, so `level` reads 2 (encoding: 0 none, 1 level one, 2 level two; 3 never appears).
- R2: `level` is 2 when the entry word equals the level-2 setting, otherwise 1 when it equals the level-1 setting, otherwise 0.
- R3: Writes to 88h–8Bh update the entry word at any level, 88h being the most significant byte; they never raise `mem_we`.
- R4: Writes to 90h–93h (level-1 setting) and 94h–97h (level-2 setting), MSB at the lowest address, are accepted only at level 2. Bytes are staged, and the setting changes only when its last byte (93h or 97h) is written. A rejected write leaves the setting unchanged.
- R5: A read of 88h–8Bh or 90h–97h returns 00h at every level.
- R6: Writes to 80h–87h raise `mem_we` at level 1 or 2, and not at level 0.
- R7: Writes to 00h–7Fh and 98h–FFh raise `mem_we` only at level 2.
- R8: Writes to 8Ch–8Eh raise `mem_we` at any level; a write to 8Fh never does.
- R9: A read of any location outside R5 returns `mem_rdata` unchanged at any level.
- R10: `mem_we` is high only while `acc_valid` and `acc_write` are high; with `acc_valid` low, `rd_data` is 00h.
- R11: `level` changes only in the cycle after an accepted write to the entry word or a setting commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (8) | Byte address |
| acc_wdata | input | DATA_W (8) | Write data |
| mem_rdata | input | DATA_W (8) | Raw read data from the memory |
| mem_we | output | 1 | Gated write enable to the memory |
| rd_data | output | DATA_W (8) | Read data after masking |
| level | output | 2 | Current privilege level |

## Verification
The bench builds the guard with its default parameters: 8-bit addresses, 8-bit data, 4-byte keys and staged setting commits. With an 8-bit address every region of the map can be reached, including the boundary addresses 7Fh/80h, 87h/88h, 8Fh and FFh. With 4-byte keys, a partly written entry word passes through states that match neither setting. This lets the bench show level 0 between two valid keys, and show that a setting update whose last byte is rejected does not commit.

// File: rtl/kwg_pkg.sv
package kwg_pkg;

   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_ONE  = 2'd1,
      LVL_TWO  = 2'd2
   } lvl_e;

   typedef enum logic [2:0] {
      RG_OPEN2   = 3'd0,
      RG_OPEN1   = 3'd1,
      RG_ENTRY   = 3'd2,
      RG_SCRATCH = 3'd3,
      RG_STATUS  = 3'd4,
      RG_KEY1    = 3'd5,
      RG_KEY2    = 3'd6
   } region_e;

   function automatic logic region_hidden(region_e r);
      return (r == RG_ENTRY) || (r == RG_KEY1) || (r == RG_KEY2);
   endfunction

endpackage

// File: rtl/kwg_region_dec.sv
module kwg_region_dec
   import kwg_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int KEY_BYTES  = 4,
   parameter int IDX_W      = 2,
   parameter int ENTRY_BASE = 'h88,
   parameter int KEY1_BASE  = 'h90,
   parameter int KEY2_BASE  = 'h94,
   parameter int L1_LO      = 'h80,
   parameter int L1_HI      = 'h87,
   parameter int SCR_LO     = 'h8C,
   parameter int SCR_HI     = 'h8E,
   parameter int STAT_ADDR  = 'h8F
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [IDX_W-1:0]  byte_idx
);

   int a_i;
   assign a_i = int'(addr);

   always_comb begin
      region   = RG_OPEN2;
      byte_idx = '0;
      if (a_i >= ENTRY_BASE && a_i < ENTRY_BASE + KEY_BYTES) begin
         region   = RG_ENTRY;
         byte_idx = IDX_W'(a_i - ENTRY_BASE);
      end else if (a_i >= KEY1_BASE && a_i < KEY1_BASE + KEY_BYTES) begin
         region   = RG_KEY1;
         byte_idx = IDX_W'(a_i - KEY1_BASE);
      end else if (a_i >= KEY2_BASE && a_i < KEY2_BASE + KEY_BYTES) begin
         region   = RG_KEY2;
         byte_idx = IDX_W'(a_i - KEY2_BASE);
      end else if (a_i >= SCR_LO && a_i <= SCR_HI) begin
         region   = RG_SCRATCH;
      end else if (a_i == STAT_ADDR) begin
         region   = RG_STATUS;
      end else if (a_i >= L1_LO && a_i <= L1_HI) begin
         region   = RG_OPEN1;
      end
   end

endmodule

// File: rtl/kwg_key_bank.sv
module kwg_key_bank #(
   parameter int DATA_W    = 8,
   parameter int KEY_BYTES = 4,
   parameter int IDX_W     = 2,
   parameter bit STAGED    = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            byte_idx,
   input  logic [DATA_W-1:0]           wdata,
   output logic [KEY_BYTES*DATA_W-1:0] key_word
);

   localparam int KEY_W = KEY_BYTES * DATA_W;
   localparam int LAST  = KEY_BYTES - 1;

   for (genvar j = 0; j < KEY_BYTES; j++) begin : g_byte
      logic [DATA_W-1:0] held_q;
      logic [DATA_W-1:0] next_b;
      logic              hit;

      if (STAGED && (j != LAST)) begin : g_stage
         logic [DATA_W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q <= '0;
            else if (wr_en && (byte_idx == IDX_W'(j)))
               stage_q <= wdata;
         end
         assign next_b = stage_q;
      end else begin : g_direct
         assign next_b = wdata;
      end

      if (STAGED) begin : g_commit_last
         assign hit = wr_en && (byte_idx == IDX_W'(LAST));
      end else begin : g_commit_each
         assign hit = wr_en && (byte_idx == IDX_W'(j));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held_q <= '0;
         else if (hit)
            held_q <= next_b;
      end

      assign key_word[KEY_W-1-j*DATA_W -: DATA_W] = held_q;
   end

endmodule

// File: rtl/kwg_level_eval.sv
module kwg_level_eval
   import kwg_pkg::*;
#(
   parameter int KEY_W = 32
) (
   input  logic [KEY_W-1:0] entry_word,
   input  logic [KEY_W-1:0] key1_word,
   input  logic [KEY_W-1:0] key2_word,
   output lvl_e             lvl
);

   always_comb begin
      if (entry_word == key2_word)
         lvl = LVL_TWO;
      else if (entry_word == key1_word)
         lvl = LVL_ONE;
      else
         lvl = LVL_NONE;
   end

endmodule

// File: rtl/kwg_policy.sv
module kwg_policy
   import kwg_pkg::*;
(
   input  region_e region,
   input  lvl_e    lvl,
   input  logic    acc_valid,
   input  logic    acc_write,
   output logic    ext_we,
   output logic    entry_we,
   output logic    key1_we,
   output logic    key2_we,
   output logic    visible
);

   logic wr_req;
   logic allow;

   assign wr_req = acc_valid && acc_write;

   always_comb begin
      unique case (region)
         RG_OPEN2:   allow = (lvl == LVL_TWO);
         RG_OPEN1:   allow = (lvl != LVL_NONE);
         RG_SCRATCH: allow = 1'b1;
         RG_STATUS:  allow = 1'b0;
         RG_ENTRY:   allow = 1'b1;
         RG_KEY1:    allow = (lvl == LVL_TWO);
         RG_KEY2:    allow = (lvl == LVL_TWO);
         default:    allow = 1'b0;
      endcase
   end

   assign visible  = !region_hidden(region);
   assign ext_we   = wr_req && allow && visible;
   assign entry_we = wr_req && allow && (region == RG_ENTRY);
   assign key1_we  = wr_req && allow && (region == RG_KEY1);
   assign key2_we  = wr_req && allow && (region == RG_KEY2);

endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard
   import kwg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int KEY_BYTES   = 4,
   parameter int ENTRY_BASE  = 'h88,
   parameter int KEY1_BASE   = 'h90,
   parameter int KEY2_BASE   = 'h94,
   parameter int L1_LO       = 'h80,
   parameter int L1_HI       = 'h87,
   parameter int SCR_LO      = 'h8C,
   parameter int SCR_HI      = 'h8E,
   parameter int STAT_ADDR   = 'h8F,
   parameter bit STAGED_KEYS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        level
);

   localparam int KEY_W = KEY_BYTES * DATA_W;
   localparam int IDX_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;
   localparam int SPAN  = 1 << ADDR_W;

   if (ADDR_W < 4 || ADDR_W > 16) begin : g_bad_addr_w
      $error("keyed_write_guard: ADDR_W must lie in 4..16");
   end
   if (DATA_W < 1 || KEY_BYTES < 1) begin : g_bad_key_shape
      $error("keyed_write_guard: DATA_W and KEY_BYTES must be positive");
   end
   if (ENTRY_BASE + KEY_BYTES > SPAN || KEY1_BASE + KEY_BYTES > SPAN ||
       KEY2_BASE + KEY_BYTES > SPAN) begin : g_bad_key_place
      $error("keyed_write_guard: key window outside address space");
   end
   if ((KEY1_BASE < KEY2_BASE + KEY_BYTES) && (KEY2_BASE < KEY1_BASE + KEY_BYTES))
   begin : g_bad_key_overlap
      $error("keyed_write_guard: setting windows overlap");
   end

   region_e          region;
   logic [IDX_W-1:0] byte_idx;
   lvl_e             lvl;
   logic             ext_we, entry_we, key1_we, key2_we, visible;
   logic [KEY_W-1:0] entry_word, key1_word, key2_word;

   kwg_region_dec #(
      .ADDR_W(ADDR_W), .KEY_BYTES(KEY_BYTES), .IDX_W(IDX_W),
      .ENTRY_BASE(ENTRY_BASE), .KEY1_BASE(KEY1_BASE), .KEY2_BASE(KEY2_BASE),
      .L1_LO(L1_LO), .L1_HI(L1_HI), .SCR_LO(SCR_LO), .SCR_HI(SCR_HI),
      .STAT_ADDR(STAT_ADDR)
   ) dec_i (
      .addr(acc_addr), .region(region), .byte_idx(byte_idx)
   );

   kwg_policy pol_i (
      .region(region), .lvl(lvl), .acc_valid(acc_valid), .acc_write(acc_write),
      .ext_we(ext_we), .entry_we(entry_we), .key1_we(key1_we),
      .key2_we(key2_we), .visible(visible)
   );

   kwg_key_bank #(
      .DATA_W(DATA_W), .KEY_BYTES(KEY_BYTES), .IDX_W(IDX_W), .STAGED(1'b0)
   ) entry_i (
      .clk(clk), .rst_n(rst_n), .wr_en(entry_we), .byte_idx(byte_idx),
      .wdata(acc_wdata), .key_word(entry_word)
   );

   kwg_key_bank #(
      .DATA_W(DATA_W), .KEY_BYTES(KEY_BYTES), .IDX_W(IDX_W), .STAGED(STAGED_KEYS)
   ) key1_i (
      .clk(clk), .rst_n(rst_n), .wr_en(key1_we), .byte_idx(byte_idx),
      .wdata(acc_wdata), .key_word(key1_word)
   );

   kwg_key_bank #(
      .DATA_W(DATA_W), .KEY_BYTES(KEY_BYTES), .IDX_W(IDX_W), .STAGED(STAGED_KEYS)
   ) key2_i (
      .clk(clk), .rst_n(rst_n), .wr_en(key2_we), .byte_idx(byte_idx),
      .wdata(acc_wdata), .key_word(key2_word)
   );

   kwg_level_eval #(.KEY_W(KEY_W)) lvl_i (
      .entry_word(entry_word), .key1_word(key1_word), .key2_word(key2_word),
      .lvl(lvl)
   );

   assign mem_we  = ext_we;
   assign rd_data = (acc_valid && !acc_write && visible) ? mem_rdata : '0;
   assign level   = lvl;

endmodule

// File: rtl/kwg_checker.sv
module kwg_checker #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int KEY_BYTES  = 4,
   parameter int ENTRY_BASE = 'h88,
   parameter int KEY1_BASE  = 'h90,
   parameter int KEY2_BASE  = 'h94,
   parameter int L1_LO      = 'h80,
   parameter int L1_HI      = 'h87,
   parameter int STAT_ADDR  = 'h8F
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              mem_we,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        level
);

   int  a_i;
   logic in_entry, in_keys, in_l1, in_open2;

   assign a_i      = int'(acc_addr);
   assign in_entry = (a_i >= ENTRY_BASE) && (a_i < ENTRY_BASE + KEY_BYTES);
   assign in_keys  = ((a_i >= KEY1_BASE) && (a_i < KEY1_BASE + KEY_BYTES)) ||
                     ((a_i >= KEY2_BASE) && (a_i < KEY2_BASE + KEY_BYTES));
   assign in_l1    = (a_i >= L1_LO) && (a_i <= L1_HI);
   assign in_open2 = (a_i < L1_LO) || (a_i >= KEY2_BASE + KEY_BYTES && a_i != STAT_ADDR);

   // R10: memory write only during a valid write access
   assert_we_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (acc_valid && acc_write));

   // R3 / R4: internal words never leak a memory write
   assert_internal_no_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_entry || in_keys) |-> !mem_we);

   // R8: status byte is read-only
   assert_status_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_i == STAT_ADDR) |-> !mem_we);

   // R5: hidden reads return zero
   assert_hidden_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && (in_entry || in_keys)) |-> (rd_data == '0));

   // R6: level-1 area needs some level
   assert_l1_area_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && in_l1) |-> (level != 2'd0));

   // R7: level-2 areas need level 2
   assert_l2_area_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && in_open2) |-> (level == 2'd2));

   // R2: encoding 3 never appears
   assert_level_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      level != 2'd3);

   // R11: no write, no level change
   assert_level_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write) |=> $stable(level));

endmodule

bind keyed_write_guard kwg_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_BYTES(KEY_BYTES),
   .ENTRY_BASE(ENTRY_BASE), .KEY1_BASE(KEY1_BASE), .KEY2_BASE(KEY2_BASE),
   .L1_LO(L1_LO), .L1_HI(L1_HI), .STAT_ADDR(STAT_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .acc_addr(acc_addr), .mem_we(mem_we), .rd_data(rd_data), .level(level)
);

// File: tb/keyed_write_guard_tb_top.sv
`timescale 1ns/1ps
module keyed_write_guard_tb_top;

   typedef struct packed {
      logic       wr;
      logic [7:0] addr;
      logic [7:0] wdata;
      logic [7:0] mrd;
      logic       we;
      logic [7:0] rd;
      logic [1:0] lvl;
      logic [3:0] req;
   } vec_t;

   function automatic vec_t mk(logic wr, logic [7:0] a, logic [7:0] d, logic [7:0] m,
                               logic we, logic [7:0] rd, logic [1:0] lv, logic [3:0] rq);
      vec_t v;
      v.wr = wr; v.addr = a; v.wdata = d; v.mrd = m;
      v.we = we; v.rd = rd; v.lvl = lv; v.req = rq;
      return v;
   endfunction

   localparam int NVEC = 41;
   // lvl column is the level seen during the access, before its write edge
   localparam vec_t VEC [NVEC] = '{
      mk(1,8'h9F,8'h55,8'h00,1,8'h00,2,7),  // R7 open at reset
      mk(0,8'h9F,8'h00,8'hA5,0,8'hA5,2,9),  // R9
      mk(0,8'h90,8'h00,8'h77,0,8'h00,2,5),  // R5
      mk(1,8'h94,8'hDE,8'h00,0,8'h00,2,4),  // R4 staged
      mk(1,8'h95,8'hAD,8'h00,0,8'h00,2,4),
      mk(1,8'h96,8'hBE,8'h00,0,8'h00,2,4),
      mk(1,8'h97,8'hEF,8'h00,0,8'h00,2,4),  // R4 commit
      mk(0,8'h00,8'h00,8'h3C,0,8'h3C,1,2),  // R2 level one
      mk(1,8'h84,8'h09,8'h00,1,8'h00,1,6),  // R6
      mk(1,8'h10,8'h01,8'h00,0,8'h00,1,7),  // R7
      mk(1,8'h90,8'h12,8'h00,0,8'h00,1,4),  // R4 rejected
      mk(1,8'h93,8'h78,8'h00,0,8'h00,1,4),  // R4 rejected commit
      mk(1,8'h8C,8'hAA,8'h00,1,8'h00,1,8),  // R8
      mk(1,8'h8F,8'h01,8'h00,0,8'h00,1,8),  // R8 status
      mk(1,8'h88,8'hDE,8'h00,0,8'h00,1,3),  // R3
      mk(1,8'h89,8'hAD,8'h00,0,8'h00,0,3),
      mk(1,8'h8A,8'hBE,8'h00,0,8'h00,0,3),
      mk(1,8'h84,8'h00,8'h00,0,8'h00,0,6),  // R6 blocked
      mk(1,8'h8D,8'h33,8'h00,1,8'h00,0,8),  // R8
      mk(0,8'h88,8'h00,8'h99,0,8'h00,0,5),  // R5
      mk(1,8'h8B,8'hEF,8'h00,0,8'h00,0,3),
      mk(0,8'h84,8'h00,8'h5A,0,8'h5A,2,11), // R11
      mk(1,8'h90,8'h12,8'h00,0,8'h00,2,4),
      mk(1,8'h91,8'h34,8'h00,0,8'h00,2,4),
      mk(1,8'h92,8'h56,8'h00,0,8'h00,2,4),
      mk(1,8'h93,8'h78,8'h00,0,8'h00,2,4),
      mk(1,8'h88,8'h12,8'h00,0,8'h00,2,3),
      mk(1,8'h89,8'h34,8'h00,0,8'h00,0,3),
      mk(1,8'h8A,8'h56,8'h00,0,8'h00,0,3),
      mk(1,8'h8B,8'h78,8'h00,0,8'h00,0,3),
      mk(0,8'h80,8'h00,8'h11,0,8'h11,1,2),  // R2
      mk(1,8'h85,8'h01,8'h00,1,8'h00,1,6),
      mk(1,8'hFF,8'h01,8'h00,0,8'h00,1,7),
      mk(1,8'h97,8'h00,8'h00,0,8'h00,1,4),
      mk(0,8'h94,8'h00,8'h66,0,8'h00,1,5),
      mk(1,8'h88,8'hDE,8'h00,0,8'h00,1,3),
      mk(1,8'h89,8'hAD,8'h00,0,8'h00,0,3),
      mk(1,8'h8A,8'hBE,8'h00,0,8'h00,0,3),
      mk(1,8'h8B,8'hEF,8'h00,0,8'h00,0,3),
      mk(1,8'h00,8'h01,8'h00,1,8'h00,2,7),
      mk(0,8'h8F,8'h00,8'hC3,0,8'hC3,2,9)
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic       acc_write = 1'b0;
   logic [7:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] mem_rdata = '0;
   logic       mem_we;
   logic [7:0] rd_data;
   logic [1:0] level;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   keyed_write_guard dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .rd_data(rd_data), .level(level)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] m);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d; mem_rdata = m;
      #2;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk("R1", "level after reset", level, 2);
      chk("R10", "we idle", mem_we, 0);

      // R10: write strobe without valid
      acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 8'h10; mem_rdata = 8'hFF; #1;
      chk("R10", "we without valid", mem_we, 0);
      chk("R10", "rd without valid", rd_data, 0);

      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = $sformatf("R%0d", VEC[i].req);
         access(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].mrd);
         chk(tag, $sformatf("vec%0d level", i), level, VEC[i].lvl);
         chk(tag, $sformatf("vec%0d mem_we", i), mem_we, VEC[i].we);
         chk(tag, $sformatf("vec%0d rd_data", i), rd_data, VEC[i].rd);
      end

      // R1: drop to level 0, then reset restores zero words and level 2
      access(1'b1, 8'h88, 8'h00, 8'h00);
      @(negedge clk); acc_valid = 1'b0; #2;
      chk("R2", "level after entry break", level, 0);
      rst_n = 1'b0; #2;
      chk("R1", "level in reset", level, 2);
      @(negedge clk); rst_n = 1'b1;
      access(1'b1, 8'h20, 8'h01, 8'h00);
      chk("R1", "level-2 write after reset", mem_we, 1);
      @(negedge clk); acc_valid = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule